// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects service requests from a parameterized set of sources and offers one of them at a time to a processor as a vectored interrupt. Each source owns an 8-bit control word. The word holds a pending flag, an enable bit, an edge-mode field and a four-bit priority level, which gives sixteen levels. The low-numbered sources are fast external pins. Each pin passes through a synchronizer and an edge detector that can fire on a rising edge, a falling edge, both edges or neither. The remaining sources are internal event pulses. A software-trap input sets the pending flag of the source whose trap number it carries.

The controller keeps a stack of the priority levels of the services now in progress. The top of the stack is the current processor level, which is zero when no service is running. A request is offered only if it is enabled, pending and strictly above that level. When the processor acknowledges the offered request, its pending flag clears and its level is pushed. A return pulse pops the stack, and lower-level requests can then be offered again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every control word is zero, `irq_o` is low and `cur_lvl_o` is zero.
- R2: A write with `cfg_we` high replaces the control word of source `cfg_sel` with `cfg_wdata`, laid out as bit 7 pending, bit 6 enable, bits 5:4 edge mode, bits 3:0 priority. For an internal source `s` (index at or above `NUM_FAST`), a high `evt_i[s-NUM_FAST]` sets that source's pending flag at the next clock edge.
- R3: `irq_o` is high exactly when some source is pending, enabled and has a priority above `cur_lvl_o`. A disabled source or a level-0 source is never offered.
- R4: Among the eligible sources the highest priority wins, and a tie goes to the lower index. `irq_src_o` gives the winning index, `irq_lvl_o` its level, and `irq_vec_o` = `VEC_BASE` + 4·index (0x60, 0x64, …). All three read zero while `irq_o` is low.
- R5: `ack_i` while `irq_o` is high clears the winner's pending flag and pushes its level, so that level appears on `cur_lvl_o` after the edge. `ack_i` while `irq_o` is low has no effect.
- R6: `reti_i` pops one level from the stack, unless an accepted acknowledge arrives in the same cycle. A return with an empty stack is ignored, and `cur_lvl_o` changes only through an acknowledge or a return.
- R7: A request whose level equals or is below the running level is held back until the stack drops below it.
- R8: For a fast source, edge-mode 01 detects rising edges, 10 falling edges, 11 both and 00 none. After a pin change, the pending flag sets on the third rising clock edge.
- R9: `swtrap_valid` with trap number n sets the pending flag of source n − `VEC_BASE`/4 when that index exists, whatever the enable bit. Other trap numbers change nothing.
- R10: A register write to a source takes precedence over a same-cycle event or acknowledge. A same-cycle event takes precedence over the acknowledge clear, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | $clog2(NUM_SRC) | Source index being written |
| cfg_wdata | input | 8 | New control word |
| evt_i | input | NUM_SRC-NUM_FAST | Event pulses of the internal sources |
| fast_pin_i | input | NUM_FAST | Asynchronous fast external pins |
| swtrap_valid | input | 1 | Software trap strobe |
| swtrap_num | input | TRAP_W | Software trap number |
| ack_i | input | 1 | Processor accepts the offered interrupt |
| reti_i | input | 1 | Processor returns from the running service |
| irq_o | output | 1 | An interrupt is offered |
| irq_src_o | output | $clog2(NUM_SRC) | Index of the offered source |
| irq_lvl_o | output | 4 | Level of the offered source |
| irq_vec_o | output | VEC_W | Vector address of the offered source |
| cur_lvl_o | output | 4 | Level of the running service, zero when idle |

## Verification
The offer outputs are combinational from registered state. A write, an event pulse, a trap, an acknowledge or a return therefore shows on `irq_o` and `cur_lvl_o` at the falling edge that follows the next rising edge. A fast-pin change needs three rising edges before its request appears. The bench drives every input at a falling edge and advances a reference model by exactly one rising edge. It compares all outputs at the following falling edge, so each result is sampled in the cycle it is due. For the fast-pin delay, extra checks confirm that the request is absent after the second edge and present after the third.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int IVC_PRIO_W = 4;
   localparam int IVC_CFG_W  = 8;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   typedef struct packed {
      logic                  pend;
      logic                  en;
      edge_mode_e            mode;
      logic [IVC_PRIO_W-1:0] prio;
   } src_ctrl_t;
endpackage

// File: rtl/ivc_edge_det.sv
module ivc_edge_det
   import ivc_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  edge_mode_e mode_i,
   output logic       hit_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              rise, fall;

   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "ivc_edge_det: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise  = sync_q[STAGES-1] & ~prev_q;
   assign fall  = ~sync_q[STAGES-1] & prev_q;
   assign hit_o = (rise && (mode_i == EDGE_RISE || mode_i == EDGE_BOTH)) ||
                  (fall && (mode_i == EDGE_FALL || mode_i == EDGE_BOTH));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
   parameter int N  = 8,
   parameter int PW = 4
) (
   input  logic [N-1:0]         req_i,
   input  logic [PW-1:0]        prio_i [N],
   input  logic [PW-1:0]        floor_i,
   output logic                 valid_o,
   output logic [$clog2(N)-1:0] idx_o,
   output logic [PW-1:0]        lvl_o
);
   localparam int IW = $clog2(N);
   logic [PW-1:0] best;

   always_comb begin
      best    = floor_i;
      idx_o   = '0;
      valid_o = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && prio_i[i] > best) begin
            best    = prio_i[i];
            idx_o   = IW'(i);
            valid_o = 1'b1;
         end
      end
      lvl_o = valid_o ? best : '0;
   end
endmodule

// File: rtl/ivc_lvl_stack.sv
module ivc_lvl_stack #(
   parameter int LW    = 4,
   parameter int DEPTH = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [LW-1:0] lvl_i,
   input  logic          pop_i,
   output logic [LW-1:0] top_o
);
   localparam int CW = $clog2(DEPTH + 1);
   logic [LW-1:0] mem_q [DEPTH];
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (push_i && cnt_q != CW'(DEPTH)) begin
         mem_q[cnt_q] <= lvl_i;
         cnt_q        <= cnt_q + CW'(1);
      end else if (pop_i && cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign top_o = (cnt_q == '0) ? '0 : mem_q[cnt_q - CW'(1)];
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int NUM_SRC     = 8,
   parameter int NUM_FAST    = 4,
   parameter int VEC_W       = 16,
   parameter int VEC_BASE    = 'h60,
   parameter int TRAP_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [$clog2(NUM_SRC)-1:0] cfg_sel,
   input  logic [IVC_CFG_W-1:0]       cfg_wdata,
   input  logic [NUM_SRC-NUM_FAST-1:0] evt_i,
   input  logic [NUM_FAST-1:0]        fast_pin_i,
   input  logic                       swtrap_valid,
   input  logic [TRAP_W-1:0]          swtrap_num,
   input  logic                       ack_i,
   input  logic                       reti_i,
   output logic                       irq_o,
   output logic [$clog2(NUM_SRC)-1:0] irq_src_o,
   output logic [IVC_PRIO_W-1:0]      irq_lvl_o,
   output logic [VEC_W-1:0]           irq_vec_o,
   output logic [IVC_PRIO_W-1:0]      cur_lvl_o
);
   localparam int IDX_W     = $clog2(NUM_SRC);
   localparam int VEC_STEP  = 4;
   localparam int TRAP_BASE = VEC_BASE / VEC_STEP;
   localparam int STK_DEPTH = (1 << IVC_PRIO_W) - 1;

   if (NUM_FAST < 1 || NUM_FAST >= NUM_SRC) begin : g_bad_fast
      initial $fatal(1, "irq_vector_ctrl: need 1 <= NUM_FAST < NUM_SRC");
   end
   if (VEC_BASE % VEC_STEP != 0) begin : g_bad_base
      initial $fatal(1, "irq_vector_ctrl: VEC_BASE must be word aligned");
   end
   if (TRAP_BASE + NUM_SRC > (1 << TRAP_W)) begin : g_bad_trap
      initial $fatal(1, "irq_vector_ctrl: TRAP_W too narrow for the vector range");
   end
   if ($bits(src_ctrl_t) != IVC_CFG_W) begin : g_bad_cfg
      initial $fatal(1, "irq_vector_ctrl: control word width mismatch");
   end

   src_ctrl_t           ctrl_q   [NUM_SRC];
   logic [IVC_PRIO_W-1:0] prio_vec [NUM_SRC];
   logic [NUM_SRC-1:0]  hw_set, trap_set, req_vec;
   logic [TRAP_W-1:0]   trap_off;
   logic                trap_ok;
   logic                win_v, ack_take;
   logic [IDX_W-1:0]    win_idx;
   logic [IVC_PRIO_W-1:0] win_lvl, cur_lvl;

   assign trap_off = swtrap_num - TRAP_W'(TRAP_BASE);
   assign trap_ok  = swtrap_valid && (swtrap_num >= TRAP_W'(TRAP_BASE)) &&
                     (trap_off < TRAP_W'(NUM_SRC));

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g < NUM_FAST) begin : g_fast
         ivc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (fast_pin_i[g]),
            .mode_i (ctrl_q[g].mode),
            .hit_o  (hw_set[g])
         );
      end else begin : g_int
         assign hw_set[g] = evt_i[g-NUM_FAST];
      end
      assign trap_set[g] = trap_ok && (trap_off == TRAP_W'(g));
      assign req_vec[g]  = ctrl_q[g].pend & ctrl_q[g].en;
      assign prio_vec[g] = ctrl_q[g].prio;
   end

   ivc_arbiter #(.N(NUM_SRC), .PW(IVC_PRIO_W)) u_arb (
      .req_i   (req_vec),
      .prio_i  (prio_vec),
      .floor_i (cur_lvl),
      .valid_o (win_v),
      .idx_o   (win_idx),
      .lvl_o   (win_lvl)
   );

   assign ack_take = ack_i & win_v;

   ivc_lvl_stack #(.LW(IVC_PRIO_W), .DEPTH(STK_DEPTH)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (ack_take),
      .lvl_i  (win_lvl),
      .pop_i  (reti_i & ~ack_take),
      .top_o  (cur_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) ctrl_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (cfg_we && cfg_sel == IDX_W'(i))
               ctrl_q[i] <= src_ctrl_t'(cfg_wdata);
            else if (hw_set[i] || trap_set[i])
               ctrl_q[i].pend <= 1'b1;
            else if (ack_take && win_idx == IDX_W'(i))
               ctrl_q[i].pend <= 1'b0;
         end
      end
   end

   assign irq_o     = win_v;
   assign irq_src_o = win_v ? win_idx : '0;
   assign irq_lvl_o = win_lvl;
   assign irq_vec_o = win_v ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP) : '0;
   assign cur_lvl_o = cur_lvl;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
   parameter int LW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack_i,
   input logic          reti_i,
   input logic          irq_o,
   input logic [LW-1:0] irq_lvl_o,
   input logic [LW-1:0] cur_lvl_o
);
   AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_lvl_o > cur_lvl_o); // R7

   AST_NO_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_lvl_o != '0); // R3

   AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> cur_lvl_o == $past(irq_lvl_o)); // R5

   AST_RETI_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !(ack_i && irq_o) && cur_lvl_o != '0) |=> cur_lvl_o < $past(cur_lvl_o)); // R6

   AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ack_i && irq_o) && !reti_i) |=> $stable(cur_lvl_o)); // R6
endmodule

bind irq_vector_ctrl ivc_checker #(.LW(ivc_pkg::IVC_PRIO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_i     (ack_i),
   .reti_i    (reti_i),
   .irq_o     (irq_o),
   .irq_lvl_o (irq_lvl_o),
   .cur_lvl_o (cur_lvl_o)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
   localparam int NS = 8;
   localparam int NF = 4;
   localparam int TB = 'h18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] evt_i = '0;
   logic [3:0] fast_pin_i = '0;
   logic       swtrap_valid = 1'b0;
   logic [7:0] swtrap_num = '0;
   logic       ack_i = 1'b0;
   logic       reti_i = 1'b0;
   logic       irq_o;
   logic [2:0] irq_src_o;
   logic [3:0] irq_lvl_o;
   logic [15:0] irq_vec_o;
   logic [3:0] cur_lvl_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // reference model state
   bit       m_pend [NS];
   bit       m_en   [NS];
   bit [1:0] m_mode [NS];
   int       m_prio [NS];
   int       stk [16];
   int       sp = 0;
   bit       ms1 [NF];
   bit       ms2 [NF];
   bit       mprv [NF];

   always #10 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .evt_i(evt_i), .fast_pin_i(fast_pin_i),
      .swtrap_valid(swtrap_valid), .swtrap_num(swtrap_num),
      .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .irq_src_o(irq_src_o),
      .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o), .cur_lvl_o(cur_lvl_o)
   );

   function automatic int cur_level();
      return (sp == 0) ? 0 : stk[sp-1];
   endfunction

   // R3 / R4 / R7: eligible above running level, highest wins, lower index on tie
   function automatic void winner(output bit v, output int idx, output int lvl);
      int best = cur_level();
      v = 0; idx = 0; lvl = 0;
      for (int i = 0; i < NS; i++)
         if (m_pend[i] && m_en[i] && m_prio[i] > best) begin
            best = m_prio[i]; idx = i; v = 1;
         end
      if (v) lvl = best;
   endfunction

   function automatic bit edge_hit(bit now, bit prv, bit [1:0] mode);
      return (now && !prv && mode[0]) || (!now && prv && mode[1]);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      bit v; int idx, lvl; bit tk; bit fh [NF];
      winner(v, idx, lvl);
      tk = ack_i && v;
      for (int i = 0; i < NF; i++) fh[i] = edge_hit(ms2[i], mprv[i], m_mode[i]);
      for (int i = 0; i < NS; i++) begin
         bit tr = swtrap_valid && swtrap_num >= TB && (swtrap_num - TB) == i;
         bit ev = (i < NF) ? fh[i] : evt_i[i-NF];
         if (cfg_we && cfg_sel == i) begin
            m_pend[i] = cfg_wdata[7]; m_en[i] = cfg_wdata[6];
            m_mode[i] = cfg_wdata[5:4]; m_prio[i] = int'(cfg_wdata[3:0]);
         end else if (ev || tr) m_pend[i] = 1;
         else if (tk && idx == i) m_pend[i] = 0;
      end
      if (tk) begin stk[sp] = lvl; sp++; end
      else if (reti_i && sp > 0) sp--;
      for (int i = 0; i < NF; i++) begin
         mprv[i] = ms2[i]; ms2[i] = ms1[i]; ms1[i] = fast_pin_i[i];
      end
   endtask

   task automatic compare(string tag);
      bit v; int idx, lvl; bit ok;
      winner(v, idx, lvl);
      ok = (irq_o == v) && (cur_lvl_o == cur_level());
      if (v) ok = ok && irq_src_o == idx && irq_lvl_o == lvl && irq_vec_o == 'h60 + 4*idx;
      else   ok = ok && irq_src_o == 0 && irq_lvl_o == 0 && irq_vec_o == 0;
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual irq=%0d src=%0d lvl=%0d vec=%h cur=%0d expected irq=%0d src=%0d lvl=%0d vec=%h cur=%0d",
                  tag, irq_o, irq_src_o, irq_lvl_o, irq_vec_o, cur_lvl_o,
                  v, idx, lvl, v ? 'h60 + 4*idx : 0, cur_level());
      end
   endtask

   // inputs already driven at a falling edge; advance one rising edge and compare
   task automatic cyc(string tag);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0; evt_i = '0; swtrap_valid = 0; ack_i = 0; reti_i = 0;
      compare(tag);
   endtask

   task automatic wr(int sel, logic [7:0] d, string tag);
      cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
      cyc(tag);
   endtask

   task automatic drain();
      for (int k = 0; k < 16; k++) begin reti_i = 1; cyc("R6"); end
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin
         m_pend[i] = 0; m_en[i] = 0; m_mode[i] = 0; m_prio[i] = 0;
      end
      for (int i = 0; i < NF; i++) begin ms1[i] = 0; ms2[i] = 0; mprv[i] = 0; end
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      rst_n = 1;
      compare("R1");
      cyc("R1");
      chk("R1", irq_o, 0);
      chk("R1", cur_lvl_o, 0);

      // R8: rising-edge mode on fast source 1, level 4
      wr(1, 8'h54, "R2");
      fast_pin_i[1] = 1;
      cyc("R8"); cyc("R8");
      chk("R8", irq_o, 0);
      cyc("R8");
      chk("R8", irq_o, 1);
      chk("R8", irq_vec_o, 'h64);
      ack_i = 1; cyc("R5");
      chk("R5", cur_lvl_o, 4);
      reti_i = 1; cyc("R6");
      fast_pin_i[1] = 0;
      repeat (4) cyc("R8");
      chk("R8", irq_o, 0);
      wr(1, 8'h74, "R8");          // both edges
      fast_pin_i[1] = 1;
      repeat (3) cyc("R8");
      chk("R8", irq_o, 1);
      wr(1, 8'h64, "R8");          // falling only, flag cleared by the write
      fast_pin_i[1] = 0;
      repeat (3) cyc("R8");
      chk("R8", irq_o, 1);
      wr(1, 8'h04, "R8");          // edge mode off
      fast_pin_i[1] = 1;
      repeat (4) cyc("R8");
      chk("R8", irq_o, 0);

      // R3 / R4: disabled, then enabled, then a tie at level 7
      wr(5, 8'h87, "R3");
      chk("R3", irq_o, 0);
      wr(5, 8'hC7, "R3");
      chk("R4", irq_vec_o, 'h74);
      wr(3, 8'hC7, "R4");
      chk("R4", irq_src_o, 3);
      wr(2, 8'hC0, "R3");          // level 0 never offered
      ack_i = 1; cyc("R5");
      chk("R7", irq_o, 0);         // source 5 at equal level held
      wr(6, 8'hC9, "R7");
      ack_i = 1; cyc("R5");
      chk("R5", cur_lvl_o, 9);
      reti_i = 1; cyc("R6");
      chk("R6", cur_lvl_o, 7);
      reti_i = 1; cyc("R6");
      chk("R6", irq_src_o, 5);
      ack_i = 1; cyc("R5");
      reti_i = 1; cyc("R6");
      reti_i = 1; cyc("R6");       // empty stack
      chk("R6", cur_lvl_o, 0);
      ack_i = 1; cyc("R5");        // nothing offered, ignored
      chk("R5", cur_lvl_o, 0);

      // R9: trap to source 2 (number 0x1A), then an out-of-range number
      wr(2, 8'h43, "R9");
      swtrap_num = 8'h1A; swtrap_valid = 1; cyc("R9");
      chk("R9", irq_src_o, 2);
      ack_i = 1; cyc("R9");
      reti_i = 1; cyc("R9");
      swtrap_num = 8'h30; swtrap_valid = 1; cyc("R9");
      chk("R9", irq_o, 0);

      // R10: write beats event; event beats acknowledge clear
      evt_i[2] = 1; cfg_we = 1; cfg_sel = 3'd6; cfg_wdata = 8'h45; cyc("R10");
      chk("R10", irq_o, 0);
      evt_i[2] = 1; cyc("R2");
      chk("R2", irq_src_o, 6);
      evt_i[2] = 1; ack_i = 1; cyc("R10");
      reti_i = 1; cyc("R10");
      chk("R10", irq_src_o, 6);
      drain();

      // constrained random traffic
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 100 < 15) begin
            cfg_we = 1; cfg_sel = 3'($urandom % NS);
            cfg_wdata = 8'($urandom);
         end
         if ($urandom % 4 == 0) evt_i = 4'($urandom);
         if ($urandom % 6 == 0) fast_pin_i[$urandom % NF] ^= 1'b1;
         ack_i  = ($urandom % 3 == 0);
         reti_i = ($urandom % 5 == 0);
         if ($urandom % 20 == 0) begin
            swtrap_valid = 1; swtrap_num = 8'(20 + $urandom % 16);
         end
         cyc("R3/R4/R5/R6/R7/R8/R9/R10");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end
endmodule